// File: doc/BRIEF.md
# Branch Target Predictor with Saturating Direction Counters

This block sits in the fetch stage of a pipelined processor and guesses the next fetch address. It holds a small direct-mapped table. Each table entry stores a valid flag, an address tag, a predicted target and a two-bit saturating direction counter. The current fetch PC selects one entry. When that entry is valid, its tag matches and its counter predicts taken, the stored target becomes the next PC in the same cycle, so a correctly predicted taken branch costs no bubbles. In every other case the block presents the sequential address, which amounts to predicting not-taken.

When a branch resolves in the execute stage, a resolve port reports the branch PC, whether it was taken and where it went. If the entry for that PC hits, its counter moves up on a taken outcome and down on a not-taken outcome. If the entry misses and the branch was taken, the block installs a new entry for that branch. A branch that misses and resolves not-taken leaves the table unchanged.

Top module: `btb_predictor`

## Requirements
- R1: The table index is fetch PC bits [IDX_W+1:2] and the tag is the PC bits above them. A lookup hits only if the indexed entry is valid and its stored tag equals the PC's tag. A PC that shares the index but has a different tag misses.
- R2: On a hit, `pred_taken` equals bit 1 of the entry's counter. When `pred_taken` is 1, `pred_npc` is the stored target. The lookup is combinational and takes effect in the same cycle as the lookup.
- R3: On a miss, or on a hit whose counter bit 1 is 0, `pred_taken` is 0 and `pred_npc` is `fetch_pc + 4`.
- R4: A resolve that misses the table and is taken writes the indexed entry at the next clock edge: valid is set, the tag and target are stored, and any previous occupant of that index is replaced.
- R5: A resolve that misses the table and is not-taken changes no entry.
- R6: A newly installed entry starts with its counter at weakly taken (binary 10).
- R7: On a resolve that hits, a taken outcome increments the counter and a not-taken outcome decrements it, saturating at 11 and 00. As a result, a counter at 11 needs two not-taken outcomes before it predicts not-taken.
- R8: Reset clears every valid bit, so every lookup after reset returns the sequential PC.
- R9: When a lookup and a resolve address the same index in the same cycle, the lookup returns the contents from before the update. The update becomes visible after the clock edge.
- R10: A resolve that hits and is taken overwrites the stored target with the resolved target. A resolve that hits and is not-taken keeps the stored target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_taken | output | 1 | Prediction is taken-to-target |
| pred_npc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The prediction has no latency. The bench therefore sets `fetch_pc` after a falling edge and compares `pred_taken` and `pred_npc` 1 ns later, within the same cycle. A resolve changes the table only at the next rising edge. The bench thus presents each resolve after a falling edge and first checks a same-index lookup against the old contents, as R9 requires. It then advances its own model at the rising edge and runs the follow-up lookups only after that edge. Directed sequences cover install, aliasing, hysteresis and saturation. A long pseudo-random sweep over a few tags on every index then compares each lookup against the bench's arithmetic model.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_npc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             f_hit, u_hit;
  logic [1:0]       u_ctr_nxt;

  assign f_idx = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[ADDR_W-1:IDX_W+2];
  assign u_idx = upd_pc[IDX_W+1:2];
  assign u_tag = upd_pc[ADDR_W-1:IDX_W+2];

  assign f_hit      = vld_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign u_hit      = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
  assign pred_taken = f_hit && ctr_q[f_idx][1];
  assign pred_npc   = pred_taken ? tgt_q[f_idx] : fetch_pc + ADDR_W'(4);

  always_comb begin
    u_ctr_nxt = ctr_q[u_idx];
    if (upd_taken && ctr_q[u_idx] != 2'b11)       u_ctr_nxt = ctr_q[u_idx] + 2'b01;
    else if (!upd_taken && ctr_q[u_idx] != 2'b00) u_ctr_nxt = ctr_q[u_idx] - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= 2'b00;
      end
    end else if (upd_valid) begin
      if (u_hit) begin
        ctr_q[u_idx] <= u_ctr_nxt;
        if (upd_taken) tgt_q[u_idx] <= upd_target;
      end else if (upd_taken) begin
        vld_q[u_idx] <= 1'b1;
        tag_q[u_idx] <= u_tag;
        tgt_q[u_idx] <= upd_target;
        ctr_q[u_idx] <= 2'b10;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && u_idx == IDX_W'(i) && u_hit && upd_taken)
      |=> (ctr_q[i] >= $past(ctr_q[i]) && ctr_q[i] != 2'b00)); // R7
    AST_CTR_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && u_idx == IDX_W'(i) && u_hit && !upd_taken)
      |=> (ctr_q[i] <= $past(ctr_q[i]) && ctr_q[i] != 2'b11 && $stable(tgt_q[i]))); // R10
    AST_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && u_idx == IDX_W'(i) && !u_hit && upd_taken)
      |=> (vld_q[i] && ctr_q[i] == 2'b10 && tgt_q[i] == $past(upd_target))); // R6
    AST_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && u_idx == IDX_W'(i) && !u_hit && !upd_taken)
      |=> ($stable(vld_q[i]) && $stable(ctr_q[i]) && $stable(tag_q[i]))); // R5
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_valid && u_idx == IDX_W'(i))
      |=> ($stable(vld_q[i]) && $stable(ctr_q[i]) && $stable(tgt_q[i]))); // R4
  end
endmodule

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              pred_taken;
  logic [ADDR_W-1:0] pred_npc;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_pc = '0;
  logic              upd_taken = 1'b0;
  logic [ADDR_W-1:0] upd_target = '0;

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_npc(pred_npc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target));

  logic             m_v   [ENTRIES];
  logic [TAG_W-1:0] m_tag [ENTRIES];
  logic [ADDR_W-1:0] m_tgt [ENTRIES];
  logic [1:0]       m_ctr [ENTRIES];

  int nvec = 0, nbad = 0;
  bit done = 0;

  function automatic logic [ADDR_W-1:0] mk_pc(int tag, int idx);
    return {TAG_W'(tag), IDX_W'(idx), 2'b00};
  endfunction

  task automatic chk(string req, logic [ADDR_W-1:0] pc);
    int idx; logic hit, et; logic [ADDR_W-1:0] en;
    fetch_pc = pc;
    #1;
    idx = int'(pc[IDX_W+1:2]);
    hit = m_v[idx] && m_tag[idx] == pc[ADDR_W-1:IDX_W+2];
    et  = hit && m_ctr[idx][1];
    en  = et ? m_tgt[idx] : pc + 32'd4;
    nvec++;
    if (pred_taken !== et || pred_npc !== en) begin
      nbad++;
      $display("FAIL %s pc=%h got taken=%0b npc=%h expected taken=%0b npc=%h",
               req, pc, pred_taken, pred_npc, et, en);
    end
  endtask

  task automatic resolve(logic [ADDR_W-1:0] pc, logic tk, logic [ADDR_W-1:0] tg);
    int idx; logic hit;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    chk("R9", pc);
    @(posedge clk);
    idx = int'(pc[IDX_W+1:2]);
    hit = m_v[idx] && m_tag[idx] == pc[ADDR_W-1:IDX_W+2];
    if (hit) begin
      if (tk && m_ctr[idx] != 2'b11) m_ctr[idx] = m_ctr[idx] + 2'b01;
      else if (!tk && m_ctr[idx] != 2'b00) m_ctr[idx] = m_ctr[idx] - 2'b01;
      if (tk) m_tgt[idx] = tg;
    end else if (tk) begin
      m_v[idx] = 1'b1; m_tag[idx] = pc[ADDR_W-1:IDX_W+2];
      m_tgt[idx] = tg; m_ctr[idx] = 2'b10;
    end
    #1 upd_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] pa, pb;
    logic [15:0] lfsr;
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b00;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < ENTRIES; i++) chk("R8", mk_pc(0, i));

    pa = mk_pc(5, 3);
    pb = mk_pc(9, 3);
    resolve(pa, 1'b0, 32'h1000);
    chk("R5", pa);
    resolve(pa, 1'b1, 32'h2000);
    chk("R4", pa);
    chk("R6", pa);
    chk("R1", pb);
    chk("R3", mk_pc(5, 4));
    resolve(pa, 1'b1, 32'h2000);
    chk("R2", pa);
    resolve(pa, 1'b1, 32'h2000);
    chk("R7", pa);
    resolve(pa, 1'b0, 32'h0);
    chk("R7", pa);
    chk("R10", pa);
    resolve(pa, 1'b0, 32'h0);
    chk("R7", pa);
    resolve(pa, 1'b0, 32'h0);
    resolve(pa, 1'b0, 32'h0);
    chk("R7", pa);
    resolve(pa, 1'b1, 32'h3000);
    chk("R3", pa);
    resolve(pa, 1'b1, 32'h3300);
    chk("R10", pa);
    resolve(pb, 1'b1, 32'h4400);
    chk("R4", pb);
    chk("R1", pa);

    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      resolve(mk_pc(int'(lfsr[5:4]), int'(lfsr[3:0])), lfsr[7] | lfsr[6],
              {16'h0, lfsr[15:2], 2'b00});
      @(negedge clk);
      chk("R2", mk_pc(int'(lfsr[9:8]), int'(lfsr[13:10])));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule